// File: doc/BRIEF.md
# Selectable Ring / Twisted-Ring Shift Counter

This block is a small shift-register counter that runs in one of two sequences. In ring mode a single set bit rotates toward the low end of the register. In twisted-ring mode, also called Johnson mode, the complement of the lowest bit is fed back into the top stage. With four stages, the ring sequence has four states and the twisted-ring sequence has eight.

The mode input is sampled only while the synchronous reset is high. Reset also loads the starting pattern, which has only the top bit set. After reset, each clock edge with enable high moves the state one step. While enable is low, the state holds. A change on the mode input outside reset has no effect until the next reset.

Top module: `ringJohnsonCounter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 4'b1000 (only bit 3 set), whatever the values of `modeSel` and `enable`.
- R2: With ring mode captured at reset (`modeSel`=0), each enabled edge moves `count` through 1000, 0100, 0010, 0001, and then back to 1000.
- R3: With twisted-ring mode captured at reset (`modeSel`=1), each enabled edge moves `count` through 1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000, and then back to 1000.
- R4: A rising edge with `enable` low and `rst` low leaves `count` unchanged.
- R5: Changing `modeSel` while `rst` is low has no effect on the sequence. The mode captured at the last reset stays in force.
- R6: On every enabled step, bit i takes the previous value of bit i+1 for each i below 3.
- R7: After a ring-mode reset, `count` has exactly one bit set at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the start pattern and samples the mode |
| modeSel | input | 1 | 0 = ring, 1 = twisted ring; sampled only during reset |
| enable | input | 1 | When high, advances the sequence one step per edge |
| count | output | 4 | Current register state |

## Verification
A wrong feedback choice becomes visible within one enabled step after the first pass through the register. For example, a ring that takes the complement shows 1100 instead of 0100 on the first step. A mode latch that is not held would let a mid-run change of `modeSel` alter the next state, and that change is visible at the next enabled edge. A stage that fails to shift or hold shows up in `count` on the cycle right after the affected edge. For this reason the bench compares the full state after every single edge.

// File: rtl/ringJohnsonPkg.sv
package ringJohnsonPkg;

  typedef enum logic {
    MODE_RING  = 1'b0,
    MODE_TWIST = 1'b1
  } counterMode_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic twist;
  } stepCtrl_t;

endpackage

// File: rtl/ringJohnsonCtrl.sv
module ringJohnsonCtrl
  import ringJohnsonPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      modeSel,
  input  logic      enable,
  output stepCtrl_t ctrl
);

  counterMode_t modeQ;

  // the mode is captured only while reset is high
  always_ff @(posedge clk) begin
    if (rst) modeQ <= counterMode_t'(modeSel);
  end

  always_comb begin
    ctrl.load  = rst;
    ctrl.shift = enable && !rst;
    ctrl.twist = (modeQ == MODE_TWIST);
  end

endmodule

// File: rtl/ringJohnsonPath.sv
module ringJohnsonPath
  import ringJohnsonPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  stepCtrl_t        ctrl,
  output logic [WIDTH-1:0] state
);

  localparam int TOP = WIDTH - 1;
  localparam logic [WIDTH-1:0] START = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] nextBit;
  logic             feedBack;

  assign feedBack = ctrl.twist ? ~stateQ[0] : stateQ[0];

  for (genvar i = 0; i < WIDTH; i++) begin : gStage
    if (i == TOP) begin : gHead
      assign nextBit[i] = feedBack;
    end else begin : gBody
      assign nextBit[i] = stateQ[i+1];
    end

    always_ff @(posedge clk) begin
      if (ctrl.load)       stateQ[i] <= START[i];
      else if (ctrl.shift) stateQ[i] <= nextBit[i];
    end
  end

  assign state = stateQ;

endmodule

// File: rtl/ringJohnsonCounter.sv
module ringJohnsonCounter
  import ringJohnsonPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic             enable,
  output logic [WIDTH-1:0] count
);

  stepCtrl_t ctrl;

  ringJohnsonCtrl ctrlI (
    .clk    (clk),
    .rst    (rst),
    .modeSel(modeSel),
    .enable (enable),
    .ctrl   (ctrl)
  );

  ringJohnsonPath #(.WIDTH(WIDTH)) pathI (
    .clk  (clk),
    .ctrl (ctrl),
    .state(count)
  );

endmodule

// File: rtl/ringJohnsonCounterChk.sv
module ringJohnsonCounterChk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             modeSel,
  input logic             enable,
  input logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] START = {1'b1, {(WIDTH-1){1'b0}}};

  logic seenReset;
  logic twistSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenReset <= 1'b1;
      twistSeen <= modeSel;
    end
  end

  // R1
  reset_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && $past(rst)) |-> (count == START));

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && !$past(rst) && !$past(enable)) |-> $stable(count));

  // R6
  stage_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && !$past(rst) && $past(enable))
      |-> (count[WIDTH-2:0] == $past(count[WIDTH-1:1])));

  // R7
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && !twistSeen) |-> ($countones(count) == 1));

  // R3
  twist_head_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && twistSeen && !$past(rst) && $past(enable))
      |-> (count[WIDTH-1] == !$past(count[0])));

  // R2
  ring_head_chk: assert property (@(posedge clk) disable iff (rst)
    (seenReset && !twistSeen && !$past(rst) && $past(enable))
      |-> (count[WIDTH-1] == $past(count[0])));

endmodule

bind ringJohnsonCounter ringJohnsonCounterChk #(.WIDTH(WIDTH)) chkI (
  .clk    (clk),
  .rst    (rst),
  .modeSel(modeSel),
  .enable (enable),
  .count  (count)
);

// File: tb/tb_ringJohnsonCounter.sv
`timescale 1ns/1ps
module tb_ringJohnsonCounter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ringJohnsonCounter #(.WIDTH(4)) dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .enable(enable), .count(count)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s: count=%b expected=%b", req, count, exp);
    end
  endtask

  task automatic doReset(input logic m, input logic en);
    @(negedge clk);
    rst = 1'b1; modeSel = m; enable = en;
    @(negedge clk);
    rst = 1'b0; enable = 1'b0;
  endtask

  task automatic step(input logic en);
    enable = en;
    @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0);
    check("R1 ring", 4'b1000);
    doReset(1'b1, 1'b1);
    check("R1 twist with enable", 4'b1000);
  endtask

  task automatic testRing();
    logic [3:0] seq [4] = '{4'b0100, 4'b0010, 4'b0001, 4'b1000};
    doReset(1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step(1'b1);
      check("R2 R7 ring step", seq[k % 4]);
    end
  endtask

  task automatic testTwist();
    logic [3:0] seq [8] = '{4'b1100, 4'b1110, 4'b1111, 4'b0111,
                            4'b0011, 4'b0001, 4'b0000, 4'b1000};
    doReset(1'b1, 1'b0);
    for (int k = 0; k < 16; k++) begin
      step(1'b1);
      check("R3 R6 twist step", seq[k % 8]);
    end
  endtask

  task automatic testHold();
    doReset(1'b1, 1'b0);
    step(1'b1); step(1'b1);
    check("R3 pre-hold", 4'b1110);
    for (int k = 0; k < 3; k++) begin
      step(1'b0);
      check("R4 hold", 4'b1110);
    end
    step(1'b1);
    check("R4 resume", 4'b1111);
  endtask

  task automatic testModeIgnored();
    doReset(1'b0, 1'b0);
    modeSel = 1'b1;
    step(1'b1); check("R5 ring kept", 4'b0100);
    step(1'b1); step(1'b1); step(1'b1);
    check("R5 ring wrap", 4'b1000);
    doReset(1'b1, 1'b0);
    modeSel = 1'b0;
    step(1'b1); check("R5 twist kept", 4'b1100);
    doReset(1'b0, 1'b0);
    step(1'b1); check("R5 new mode after reset", 4'b0100);
  endtask

  initial begin
    testReset();
    testRing();
    testTwist();
    testHold();
    testModeIgnored();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: count=%b expected=finished", count);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule